// File: doc/BRIEF.md
# Display Channel Underflow Interrupt Aggregator

This block gathers underflow pulses from three display output channels and turns them into a single interrupt request for the processor. Every channel owns a sticky status flag that is set by an underflow pulse and stays set until software clears it. Every channel also owns an interrupt enable. A master enable gates the whole request line.

Software reaches the block through a small word-wide register port: an address, write data, a write strobe and a combinational read-data output. The usual service routine masks a channel once it has been reported, by doing a read-modify-write of the control word. When the channel is re-armed, software first clears any stale flag and only then sets the enable again, so an old underflow does not raise a new interrupt. A saturating counter records how many times a flag/enable pair has become jointly active. Software can read this counter as a health figure.

Top module: `urq_ctrl`

## Requirements
- R1: After reset, all status flags, channel enables, the master enable and the event counter are zero, and `irq_o` is low.
- R2: A one-cycle pulse on `ufl_evt_i[c]` sets status flag `c` at the next rising clock edge. The flag can be read at address 1, bit `c`, right after that edge.
- R3: A write to address 1 with bit `c` set to 1 clears flag `c`. A 0 in bit `c` leaves flag `c` unchanged. Without such a write, a flag holds its value.
- R4: If an underflow pulse and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R5: The control word is at address 0. Bit 0 is the master enable and bit `1+c` is the enable of channel `c`. A write replaces the whole word and a read returns it. Control bits above bit 3 read back as 0.
- R6: `irq_o` is registered. It goes high one clock edge after some channel has both its flag and its enable set while the master enable is set.
- R7: A flag whose channel enable is 0 never raises `irq_o`. While the master enable is 0, `irq_o` is low one edge later. After a stale flag is cleared and its enable is then set, no interrupt occurs.
- R8: The counter at address 2 rises by one for each channel whose (flag AND enable) condition goes from 0 to 1. It counts on the edge after the condition appears. A condition that stays high is not counted again. Several channels that rise together add their number. The master enable does not affect counting.
- R9: The counter saturates at its all-ones value and stays there.
- R10: Writes to address 2 and address 3 change no state, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ufl_evt_i | input | NUM_CH | Per-channel underflow pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Combinational register read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Flags and control bits change at the edge that samples the pulse or the write. The read port is combinational, so the bench reads them back in the low phase right after that edge. `irq_o` and the counter sit one more register away, so they are due one edge after the flag/enable condition first holds. The bench checks them at both points: it confirms they are still unchanged right after the causing edge and correct one edge later. All stimulus is applied and sampled on the falling clock edge. For the saturation case, the bench builds the block with a narrow counter so that the limit is reached within a short run.

// File: rtl/urq_pkg.sv
package urq_pkg;

    localparam int URQ_ADDR_W = 2;

    typedef enum logic [URQ_ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CNT  = 2'd2,
        REG_RSVD = 2'd3
    } urq_reg_e;

endpackage

// File: rtl/urq_flag.sv
module urq_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic clr_i,
    output logic flag_o
);
    // Event has priority over a same-cycle clear (R4).
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (evt_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/urq_evt_counter.sv
module urq_evt_counter #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] qual_i,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [NUM_CH-1:0] qual_prev_q;
    logic [NUM_CH-1:0] rise;
    logic [CNT_W:0]    sum;

    assign rise = qual_i & ~qual_prev_q;

    always_comb begin
        sum = {1'b0, cnt_o};
        for (int i = 0; i < NUM_CH; i++) begin
            sum = sum + (CNT_W+1)'(rise[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_prev_q <= '0;
            cnt_o       <= '0;
        end else begin
            qual_prev_q <= qual_i;
            cnt_o       <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/urq_ctrl.sv
module urq_ctrl
    import urq_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     ufl_evt_i,
    input  logic                  reg_we_i,
    input  logic [URQ_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  irq_o
);
    localparam int CTRL_W = NUM_CH + 1;

    logic              glb_en_q;
    logic [NUM_CH-1:0] ch_en_q;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] qual;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              unused_wdata;

    assign wr_ctrl      = reg_we_i && (urq_reg_e'(reg_addr_i) == REG_CTRL);
    assign wr_stat      = reg_we_i && (urq_reg_e'(reg_addr_i) == REG_STAT);
    assign clr_vec      = wr_stat ? reg_wdata_i[NUM_CH-1:0] : '0;
    assign qual         = status_q & ch_en_q;
    assign unused_wdata = ^reg_wdata_i[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en_q <= 1'b0;
            ch_en_q  <= '0;
        end else if (wr_ctrl) begin
            glb_en_q <= reg_wdata_i[0];
            ch_en_q  <= reg_wdata_i[NUM_CH:1];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        urq_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .evt_i  (ufl_evt_i[c]),
            .clr_i  (clr_vec[c]),
            .flag_o (status_q[c])
        );
    end

    urq_evt_counter #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .qual_i (qual),
        .cnt_o  (cnt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= glb_en_q & (|qual);
    end

    always_comb begin
        reg_rdata_o = '0;
        case (urq_reg_e'(reg_addr_i))
            REG_CTRL: reg_rdata_o[CTRL_W-1:0] = {ch_en_q, glb_en_q};
            REG_STAT: reg_rdata_o[NUM_CH-1:0] = status_q;
            REG_CNT:  reg_rdata_o[CNT_W-1:0]  = cnt_q;
            default:  reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/urq_ctrl_chk.sv
module urq_ctrl_chk
    import urq_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_CH-1:0]     ufl_evt_i,
    input logic                  reg_we_i,
    input logic [URQ_ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0]     reg_wdata_i,
    input logic [NUM_CH-1:0]     status_q,
    input logic [NUM_CH-1:0]     ch_en_q,
    input logic                  glb_en_q,
    input logic [CNT_W-1:0]      cnt_q,
    input logic                  irq_o
);
    logic stat_wr;
    assign stat_wr = reg_we_i && (reg_addr_i == 2'd1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
            ufl_evt_i[c] |=> status_q[c]);
        a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            (stat_wr && reg_wdata_i[c] && !ufl_evt_i[c]) |=> !status_q[c]);
        a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
            (status_q[c] && !(stat_wr && reg_wdata_i[c])) |=> status_q[c]);
    end

    a_r6_irq_raise: assert property (@(posedge clk) disable iff (rst)
        (glb_en_q && ((status_q & ch_en_q) != '0)) |=> irq_o);
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (!glb_en_q || ((status_q & ch_en_q) == '0)) |=> !irq_o);
    a_r8_cnt_monotonic: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt_q >= $past(cnt_q)));
    a_r9_cnt_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == {CNT_W{1'b1}}));
endmodule

bind urq_ctrl urq_ctrl_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ufl_evt_i   (ufl_evt_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_q    (status_q),
    .ch_en_q     (ch_en_q),
    .glb_en_q    (glb_en_q),
    .cnt_q       (cnt_q),
    .irq_o       (irq_o)
);

// File: tb/urq_ctrl_bench.sv
`timescale 1ns/1ps
module urq_ctrl_bench;
    localparam int NUM_CH = 3;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 32;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] ufl_evt_i = '0;
    logic              reg_we_i = 1'b0;
    logic [1:0]        reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    urq_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_urq_ctrl (
        .clk(clk), .rst(rst), .ufl_evt_i(ufl_evt_i), .reg_we_i(reg_we_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #0.5;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] e);
        ufl_evt_i = e;
        tick();
        ufl_evt_i = '0;
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 status", d, 0);
        rd(2'd2, d); chk("R1 counter", d, 0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(2'd0, 32'h0000_000F); rd(2'd0, d); chk("R5 ctrl readback", d, 32'hF);
        wr(2'd0, 32'h0000_0005); rd(2'd0, d); chk("R5 ctrl replace", d, 32'h5);
        wr(2'd0, 32'hFFFF_FFF0); rd(2'd0, d); chk("R5 upper bits zero", d, 32'h0);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        pulse(3'b101); rd(2'd1, d); chk("R2 flags set", d, 32'h5);
        tick(); tick(); rd(2'd1, d); chk("R3 flags sticky", d, 32'h5);
        wr(2'd1, 32'h0); rd(2'd1, d); chk("R3 zero write no effect", d, 32'h5);
        wr(2'd1, 32'h1); rd(2'd1, d); chk("R3 w1c bit0", d, 32'h4);
        wr(2'd1, 32'h4); rd(2'd1, d); chk("R3 w1c bit2", d, 32'h0);
        chk("R7 no irq while disabled", irq_o, 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        ufl_evt_i = 3'b010;
        wr(2'd1, 32'h2);
        ufl_evt_i = '0;
        rd(2'd1, d); chk("R4 event beats clear", d, 32'h2);
        wr(2'd1, 32'h7); rd(2'd1, d); chk("R3 clear all", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(2'd0, 32'h3);                 // master + ch0
        pulse(3'b010); tick(); tick();
        chk("R7 masked channel no irq", irq_o, 0);
        rd(2'd2, d); chk("R8 masked not counted", d, exp_cnt);
        pulse(3'b001);
        chk("R6 irq not yet", irq_o, 0);
        rd(2'd2, d); chk("R8 count not yet", d, exp_cnt);
        tick();
        exp_cnt = sat(exp_cnt + 1);
        chk("R6 irq raised", irq_o, 1);
        rd(2'd2, d); chk("R8 counted once", d, exp_cnt);
        tick(); tick();
        rd(2'd2, d); chk("R8 held level not recounted", d, exp_cnt);
        wr(2'd0, 32'h2);                 // master off, ch0 on
        tick();
        chk("R7 master off drops irq", irq_o, 0);
        // mask ch0 by read-modify-write
        rd(2'd0, d); wr(2'd0, d & ~32'h2);
        // unmask ch1: clear stale flag first, then enable
        wr(2'd1, 32'h2);
        wr(2'd0, 32'h5);
        tick(); tick();
        chk("R7 stale flag cleared before unmask", irq_o, 0);
        rd(2'd2, d); chk("R8 no count on unmask", d, exp_cnt);
        wr(2'd1, 32'h7);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        wr(2'd0, 32'hF);
        pulse(3'b111); tick();
        exp_cnt = sat(exp_cnt + 3);
        rd(2'd2, d); chk("R8 simultaneous rises add", d, exp_cnt);
        chk("R6 irq multi", irq_o, 1);
        wr(2'd1, 32'h7);
        wr(2'd0, 32'hE);                 // master off
        pulse(3'b100); tick();
        exp_cnt = sat(exp_cnt + 1);
        rd(2'd2, d); chk("R8 counts with master off", d, exp_cnt);
        chk("R7 master off no irq", irq_o, 0);
        wr(2'd1, 32'h7);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(2'd2, 32'h0); rd(2'd2, d); chk("R10 counter write ignored", d, exp_cnt);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R10 offset3 reads zero", d, 0);
        rd(2'd0, d); chk("R10 offset3 write no ctrl change", d, 32'hE);
        rd(2'd1, d); chk("R10 offset3 write no status change", d, 0);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        wr(2'd0, 32'h3);
        for (int i = 0; i < 20; i++) begin
            wr(2'd1, 32'h1);
            pulse(3'b001);
            tick();
            exp_cnt = sat(exp_cnt + 1);
        end
        rd(2'd2, d); chk("R9 counter saturated", d, CMAX);
        chk("R9 model agrees", exp_cnt, CMAX);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_flags();
        t_collide();
        t_irq();
        t_multi();
        t_readonly();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule